// File: doc/BRIEF.md
# PHY Management Bus Master

This block runs the two-wire PHY management bus: it generates the management clock (MDC) and drives or listens on the shared data line (MDIO), so that a host can read and write 16-bit registers inside an external PHY. The data line comes out as separate output, output-enable and input pins, so a pad cell can combine them into one bidirectional pin.

The MDC divide ratio comes from a fixed, uneven table of fifteen even values from 4 to 64. By default the block takes the smallest table entry that is not below the ratio of the system clock to the fastest MDC the PHY allows. A select input can override this choice. The block samples that input only while its management reset is held. The host loads a PHY address and a register number. Loading write data starts a write frame. Setting the read command bit starts a read frame, and the bit clears by itself once the read data has been captured. A busy flag covers every frame.

Top module: `mdio_master`

## Requirements
- R1: After rst_ni: busy_o=0, mdc_o=0, mdio_oe_o=0, rd_cmd_o=0, rdata_o=0.
- R2: With cfg select 0 (auto), the divide is the first entry of the table {4,6,8,10,14,20,28,36,40,44,48,52,56,60,64} that is >= floor(SYS_CLK_HZ/MDC_MAX_HZ), or 64 if no entry qualifies. The defaults (50 MHz / 2.5 MHz) give 20, and 50 MHz / 2 MHz gives 28.
- R3: A cfg_sel_i value n in 1..15 selects table entry n-1, and 0 selects auto. cfg_sel_i is sampled only while mgmt_rst_i is high, so changes made at other times have no effect.
- R4: A write frame is 64 bits, sent MSB first: 32 ones, 01, opcode 01, the 5-bit PHY address, the 5-bit register number, turnaround 10, then the 16 data bits MSB first. MDIO is driven for all 64 bits.
- R5: A wdata_we_i pulse while idle starts a write. busy_o is high for exactly 64*div cycles, and successive MDC rising edges are div cycles apart.
- R6: A read frame carries opcode 10. MDIO is driven for the first 46 bits and released (mdio_oe_o=0) from the turnaround through the last data bit.
- R7: During a read, mdio_i is sampled at each MDC rising edge of bits 48..63, MSB first. At the end of the frame the 16 bits appear on rdata_o and rd_cmd_o clears. busy_o is high for 64*div+1 cycles. Write frames leave rdata_o unchanged.
- R8: MDC is low whenever busy_o is low. In each bit, MDC is low for the first half and high for the second, and MDIO changes only while MDC is low.
- R9: While busy_o is high, write-data loads and read-command writes are ignored. If a data load and a read-command write arrive in the same idle cycle, only the write runs.
- R10: While mgmt_rst_i is high, any frame in progress is aborted, busy_o and mdc_o are low, the read command is cleared, and new commands are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mgmt_rst_i | input | 1 | Management-logic reset (holds the block idle, samples cfg_sel_i) |
| cfg_sel_i | input | 4 | Divider select: 0 auto, 1..15 table entry plus one |
| addr_we_i | input | 1 | Load PHY address and register number |
| addr_phy_i | input | 5 | PHY device address |
| addr_reg_i | input | 5 | PHY register number |
| wdata_we_i | input | 1 | Load write data and start a write |
| wdata_i | input | 16 | Write data |
| rd_cmd_we_i | input | 1 | Write the read command bit |
| rd_cmd_i | input | 1 | Value for the read command bit |
| rd_cmd_o | output | 1 | Current read command bit |
| busy_o | output | 1 | Frame pending or in progress |
| rdata_o | output | 16 | Last captured read data |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The hardest conditions to reach are a command that lands in the middle of a frame and an abort through the management reset. The bench fires a second data load together with a read command partway through a write, issues both commands in the same idle cycle, and raises mgmt_rst_i several hundred cycles into a frame. A PHY model in the bench follows the MDC edges and returns random data on the released line, so every read-data bit is checked against what was driven. A second instance with a different clock ratio checks the table search at a non-exact ratio.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int unsigned SEL_W       = 4;
  localparam int unsigned ADR_W       = 5;
  localparam int unsigned DAT_W       = 16;
  localparam int unsigned FRAME_BITS  = 64;
  localparam int unsigned IDX_W       = $clog2(FRAME_BITS);
  localparam int unsigned RELEASE_BIT = 46;  // first bit of turnaround
  localparam int unsigned DATA_BIT    = FRAME_BITS - DAT_W;
  localparam int unsigned MAX_DIV     = 64;
  localparam int unsigned CNT_W       = $clog2(MAX_DIV / 2);

  // divide value for an encoded select (entry index + 1); 0 folds onto entry 0
  function automatic int unsigned div_of(input logic [SEL_W-1:0] sel);
    int unsigned d;
    case (sel)
      4'd0, 4'd1: d = 4;
      4'd2:       d = 6;
      4'd3:       d = 8;
      4'd4:       d = 10;
      4'd5:       d = 14;
      4'd6:       d = 20;
      4'd7:       d = 28;
      4'd8:       d = 36;
      4'd9:       d = 40;
      4'd10:      d = 44;
      4'd11:      d = 48;
      4'd12:      d = 52;
      4'd13:      d = 56;
      4'd14:      d = 60;
      default:    d = 64;
    endcase
    return d;
  endfunction

  function automatic logic [SEL_W-1:0] pick_sel(input int unsigned ratio);
    logic [SEL_W-1:0] s;
    logic             found;
    s     = 4'd15;
    found = 1'b0;
    for (int i = 1; i <= 15; i++) begin
      if (!found && div_of(SEL_W'(i)) >= ratio) begin
        s     = SEL_W'(i);
        found = 1'b1;
      end
    end
    return s;
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen
  import mdio_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] half_m1_i,
  output logic             rise_o,
  output logic             fall_o,
  output logic             mdc_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             mdc_q;
  logic             wrap;

  assign wrap   = en_i && (cnt_q == half_m1_i);
  assign rise_o = wrap && !mdc_q;
  assign fall_o = wrap && mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= !mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R8: clock parks low whenever the generator is disabled
  a_r8_mdc_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !mdc_o);
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             start_i,
  input  logic             is_rd_i,
  input  logic [ADR_W-1:0] phy_i,
  input  logic [ADR_W-1:0] reg_i,
  input  logic [DAT_W-1:0] wdata_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             mdc_i,
  input  logic             mdio_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             mdio_o,
  output logic             mdio_oe_o,
  output logic [DAT_W-1:0] rdata_o
);
  logic                  busy_q, rd_q;
  logic [IDX_W-1:0]      idx_q;
  logic [FRAME_BITS-1:0] sh_out_q;
  logic [DAT_W-1:0]      sh_in_q, rdata_q;
  logic [FRAME_BITS-1:0] frame;
  logic                  last_bit;

  always_comb begin
    frame = {{32{1'b1}}, 2'b01,
             (is_rd_i ? 2'b10 : 2'b01),
             phy_i, reg_i,
             (is_rd_i ? 2'b00 : 2'b10),
             (is_rd_i ? {DAT_W{1'b0}} : wdata_i)};
  end

  assign last_bit  = (idx_q == IDX_W'(FRAME_BITS - 1));
  assign done_o    = busy_q && fall_i && last_bit;
  assign busy_o    = busy_q;
  assign mdio_o    = busy_q ? sh_out_q[FRAME_BITS-1] : 1'b1;
  assign mdio_oe_o = busy_q && (!rd_q || (idx_q < IDX_W'(RELEASE_BIT)));
  assign rdata_o   = rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      rd_q     <= 1'b0;
      idx_q    <= '0;
      sh_out_q <= '0;
      sh_in_q  <= '0;
      rdata_q  <= '0;
    end else if (clr_i) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q   <= 1'b1;
        rd_q     <= is_rd_i;
        idx_q    <= '0;
        sh_out_q <= frame;
      end
    end else begin
      if (rise_i && rd_q && (idx_q >= IDX_W'(DATA_BIT)))
        sh_in_q <= {sh_in_q[DAT_W-2:0], mdio_i};
      if (fall_i) begin
        if (last_bit) begin
          busy_q <= 1'b0;
          if (rd_q) rdata_q <= sh_in_q;
        end else begin
          idx_q    <= idx_q + 1'b1;
          sh_out_q <= {sh_out_q[FRAME_BITS-2:0], 1'b0};
        end
      end
    end
  end

  // R8: data line holds while MDC is high
  a_r8_mdio_stable_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && $past(busy_q) && mdc_i && $past(mdc_i) |-> $stable(mdio_o));
  // R6: the line is never driven in the data phase of a read
  a_r6_read_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && rd_q && rise_i && (idx_q >= IDX_W'(DATA_BIT)) |-> !mdio_oe_o);
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int unsigned SYS_CLK_HZ = 50_000_000,
  parameter int unsigned MDC_MAX_HZ = 2_500_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mgmt_rst_i,
  input  logic [SEL_W-1:0]  cfg_sel_i,
  input  logic              addr_we_i,
  input  logic [ADR_W-1:0]  addr_phy_i,
  input  logic [ADR_W-1:0]  addr_reg_i,
  input  logic              wdata_we_i,
  input  logic [DAT_W-1:0]  wdata_i,
  input  logic              rd_cmd_we_i,
  input  logic              rd_cmd_i,
  output logic              rd_cmd_o,
  output logic              busy_o,
  output logic [DAT_W-1:0]  rdata_o,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  input  logic              mdio_i
);
  localparam int unsigned      RATIO    = SYS_CLK_HZ / MDC_MAX_HZ;
  localparam logic [SEL_W-1:0] AUTO_SEL = pick_sel(RATIO);

  logic [SEL_W-1:0] sel_q, eff_sel;
  logic [ADR_W-1:0] phy_q, reg_q;
  logic [DAT_W-1:0] wdata_q;
  logic             rd_q;
  logic [CNT_W-1:0] half_m1;
  logic             eng_busy, eng_done, rise, fall, mdc;
  logic             wr_go, rd_go, start;

  assign eff_sel = (sel_q == '0) ? AUTO_SEL : sel_q;
  always_comb half_m1 = CNT_W'(div_of(eff_sel) / 2 - 1);

  assign busy_o   = eng_busy || rd_q;
  assign wr_go    = wdata_we_i && !busy_o && !mgmt_rst_i;
  assign rd_go    = rd_q && !eng_busy && !mgmt_rst_i;
  assign start    = wr_go || rd_go;
  assign rd_cmd_o = rd_q;
  assign mdc_o    = mdc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= '0;
      phy_q   <= '0;
      reg_q   <= '0;
      wdata_q <= '0;
      rd_q    <= 1'b0;
    end else begin
      if (mgmt_rst_i) sel_q <= cfg_sel_i;
      if (addr_we_i) begin
        phy_q <= addr_phy_i;
        reg_q <= addr_reg_i;
      end
      if (wr_go) wdata_q <= wdata_i;
      if (mgmt_rst_i || eng_done)
        rd_q <= 1'b0;
      else if (rd_cmd_we_i && !busy_o && !wdata_we_i)
        rd_q <= rd_cmd_i;
    end
  end

  mdio_clkgen u_clkgen (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (eng_busy && !mgmt_rst_i),
    .half_m1_i (half_m1),
    .rise_o    (rise),
    .fall_o    (fall),
    .mdc_o     (mdc)
  );

  mdio_frame_engine u_engine (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (mgmt_rst_i),
    .start_i   (start),
    .is_rd_i   (rd_go),
    .phy_i     (phy_q),
    .reg_i     (reg_q),
    .wdata_i   (wr_go ? wdata_i : wdata_q),
    .rise_i    (rise),
    .fall_i    (fall),
    .mdc_i     (mdc),
    .mdio_i    (mdio_i),
    .busy_o    (eng_busy),
    .done_o    (eng_done),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o),
    .rdata_o   (rdata_o)
  );

  // R10: management reset leaves the block idle with MDC low
  a_r10_mgmt_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mgmt_rst_i |=> (!busy_o && !mdc_o));
  // R7: the read command never outlives the frame that served it
  a_r7_cmd_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(eng_busy) |-> !rd_q);
  // R9: write data cannot be reloaded while busy
  a_r9_wdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(wdata_q));
endmodule

// File: tb/mdio_master_bench.sv
`timescale 1ns/1ps
module mdio_master_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mgmt_rst_i = 1'b0;
  logic [3:0]  cfg_sel_i = 4'd0;
  logic        addr_we_i = 1'b0;
  logic [4:0]  addr_phy_i = '0, addr_reg_i = '0;
  logic        wdata_we_i = 1'b0;
  logic [15:0] wdata_i = '0;
  logic        rd_cmd_we_i = 1'b0, rd_cmd_i = 1'b0;
  logic        rd_cmd_o, busy_o, mdc_o, mdio_o, mdio_oe_o, mdio_i;
  logic [15:0] rdata_o;
  logic        a_busy, a_mdc, a_mdio, a_oe, a_rdc;
  logic [15:0] a_rdata;

  int checks = 0, fails = 0;
  int cyc = 0, busy_cnt = 0, rises = 0, last_rise = -1, per_err = 0;
  int idle_err = 0, stab_err = 0, exp_div = 20;
  int a_rises = 0, a_last = -1, a_per_err = 0;
  logic [63:0] cap_bits, cap_oe;
  logic [15:0] phy_val = '0;
  logic        mdc_prev = 1'b0, mdio_prev = 1'b1, a_prev = 1'b0;

  always #10 clk_i = ~clk_i;
  always @(posedge clk_i) cyc++;

  assign mdio_i = (rises >= 48 && rises < 64) ? phy_val[63 - rises] : 1'b1;

  mdio_master u_mdio_master (
    .clk_i, .rst_ni, .mgmt_rst_i, .cfg_sel_i, .addr_we_i, .addr_phy_i, .addr_reg_i,
    .wdata_we_i, .wdata_i, .rd_cmd_we_i, .rd_cmd_i, .rd_cmd_o, .busy_o, .rdata_o,
    .mdc_o, .mdio_o, .mdio_oe_o, .mdio_i);

  mdio_master #(.SYS_CLK_HZ(50_000_000), .MDC_MAX_HZ(2_000_000)) u_alt (
    .clk_i, .rst_ni, .mgmt_rst_i(1'b0), .cfg_sel_i(4'd0), .addr_we_i, .addr_phy_i,
    .addr_reg_i, .wdata_we_i, .wdata_i, .rd_cmd_we_i, .rd_cmd_i, .rd_cmd_o(a_rdc),
    .busy_o(a_busy), .rdata_o(a_rdata), .mdc_o(a_mdc), .mdio_o(a_mdio),
    .mdio_oe_o(a_oe), .mdio_i(1'b1));

  always @(negedge clk_i) begin
    if (busy_o) busy_cnt++;
    if (!mdc_prev && mdc_o) begin
      if (rises < 64) begin
        cap_bits[63 - rises] = mdio_o;
        cap_oe[63 - rises]   = mdio_oe_o;
      end
      if (last_rise >= 0 && (cyc - last_rise) != exp_div) per_err++;
      last_rise = cyc;
      rises++;
    end
    if (!busy_o && mdc_o) idle_err++;
    if (mdc_o && mdc_prev && mdio_oe_o && mdio_o !== mdio_prev) stab_err++;
    if (!busy_o) begin rises = 0; last_rise = -1; end
    mdc_prev  = mdc_o;
    mdio_prev = mdio_o;
    if (!a_prev && a_mdc) begin
      if (a_last >= 0 && (cyc - a_last) != 28) a_per_err++;
      a_last = cyc;
      a_rises++;
    end
    if (!a_busy) a_last = -1;
    a_prev = a_mdc;
  end

  function automatic logic [63:0] exp_frame(bit rd, logic [4:0] p, logic [4:0] r, logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), p, r, (rd ? 2'b00 : 2'b10),
            (rd ? 16'h0 : d)};
  endfunction
  function automatic logic [63:0] exp_oe(bit rd);
    return rd ? {{46{1'b1}}, {18{1'b0}}} : {64{1'b1}};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wait_idle();
    do @(negedge clk_i); while (busy_o);
  endtask

  task automatic set_addr(input logic [4:0] p, input logic [4:0] r);
    @(negedge clk_i);
    addr_we_i = 1'b1; addr_phy_i = p; addr_reg_i = r;
    @(negedge clk_i);
    addr_we_i = 1'b0;
  endtask

  task automatic run_op(input bit rd, input logic [4:0] p, input logic [4:0] r,
                        input logic [15:0] d, input int div, input string req);
    logic [63:0] m, e;
    logic [15:0] old_rd;
    old_rd = rdata_o;
    exp_div = div;
    per_err = 0;
    cap_bits = '0; cap_oe = '0;
    if (rd) phy_val = d;
    set_addr(p, r);
    busy_cnt = 0;
    if (rd) begin rd_cmd_we_i = 1'b1; rd_cmd_i = 1'b1; end
    else begin wdata_we_i = 1'b1; wdata_i = d; end
    @(negedge clk_i);
    rd_cmd_we_i = 1'b0; wdata_we_i = 1'b0;
    wait_idle();
    m = exp_oe(rd);
    e = exp_frame(rd, p, r, d);
    check((cap_bits & m) == (e & m), rd ? "R6" : "R4", "frame bits", cap_bits & m, e & m);
    check(cap_oe == m, rd ? "R6" : "R4", "drive mask", cap_oe, m);
    check(busy_cnt == 64 * div + (rd ? 1 : 0), rd ? "R7" : "R5", "busy cycles",
          64'(busy_cnt), 64'(64 * div + (rd ? 1 : 0)));
    check(per_err == 0, req, "mdc period errors", 64'(per_err), 64'(0));
    if (rd) begin
      check(rdata_o == d, "R7", "read data", 64'(rdata_o), 64'(d));
      check(rd_cmd_o == 1'b0, "R7", "cmd bit cleared", 64'(rd_cmd_o), 64'(0));
    end else begin
      check(rdata_o == old_rd, "R7", "rdata kept on write", 64'(rdata_o), 64'(old_rd));
    end
  endtask

  initial begin
    #(200000 * 20);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] d;
    void'($urandom(32'h1F2E3D4C));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1
    check({busy_o, mdc_o, mdio_oe_o, rd_cmd_o} == 4'b0 && rdata_o == 16'h0, "R1",
          "reset state", {busy_o, mdc_o, mdio_oe_o, rd_cmd_o, rdata_o}, 64'h0);

    // R2 auto divide 20, R4/R5 write
    run_op(1'b0, 5'h01, 5'h00, 16'h8000, 20, "R2");
    // R6/R7 read
    run_op(1'b1, 5'h1F, 5'h11, 16'hA5C3, 20, "R2");

    // R9: commands issued mid-frame are ignored
    set_addr(5'h03, 5'h04);
    cap_bits = '0;
    wdata_we_i = 1'b1; wdata_i = 16'h1234;
    @(negedge clk_i); wdata_we_i = 1'b0;
    repeat (100) @(negedge clk_i);
    wdata_we_i = 1'b1; wdata_i = 16'hFFFF; rd_cmd_we_i = 1'b1; rd_cmd_i = 1'b1;
    @(negedge clk_i); wdata_we_i = 1'b0; rd_cmd_we_i = 1'b0;
    wait_idle();
    check(cap_bits == exp_frame(1'b0, 5'h03, 5'h04, 16'h1234), "R9", "frame kept",
          cap_bits, exp_frame(1'b0, 5'h03, 5'h04, 16'h1234));
    busy_cnt = 0;
    repeat (50) @(negedge clk_i);
    check(busy_cnt == 0 && rd_cmd_o == 1'b0, "R9", "no follow-up frame",
          64'(busy_cnt), 64'(0));

    // R9: simultaneous load and read command -> write only
    cap_bits = '0;
    wdata_we_i = 1'b1; wdata_i = 16'h0F0F; rd_cmd_we_i = 1'b1; rd_cmd_i = 1'b1;
    @(negedge clk_i); wdata_we_i = 1'b0; rd_cmd_we_i = 1'b0;
    check(rd_cmd_o == 1'b0, "R9", "read cmd dropped", 64'(rd_cmd_o), 64'(0));
    wait_idle();
    check(cap_bits == exp_frame(1'b0, 5'h03, 5'h04, 16'h0F0F), "R9", "write ran",
          cap_bits, exp_frame(1'b0, 5'h03, 5'h04, 16'h0F0F));

    // R10: abort mid-frame
    wdata_we_i = 1'b1; wdata_i = 16'h5555;
    @(negedge clk_i); wdata_we_i = 1'b0;
    repeat (300) @(negedge clk_i);
    mgmt_rst_i = 1'b1;
    @(negedge clk_i);
    check(!busy_o && !mdc_o, "R10", "abort idle", {busy_o, mdc_o}, 64'h0);
    rd_cmd_we_i = 1'b1; rd_cmd_i = 1'b1; wdata_we_i = 1'b1;
    cfg_sel_i = 4'd3;  // R3: divide 8
    @(negedge clk_i); rd_cmd_we_i = 1'b0; wdata_we_i = 1'b0;
    repeat (5) @(negedge clk_i);
    check(!busy_o && !rd_cmd_o && !mdc_o, "R10", "commands ignored in reset",
          {busy_o, rd_cmd_o, mdc_o}, 64'h0);
    mgmt_rst_i = 1'b0;
    @(negedge clk_i);

    // R3 random traffic at divide 8
    for (int i = 0; i < 16; i++) begin
      d = 16'($urandom);
      run_op(1'($urandom), 5'($urandom), 5'($urandom), d, 8, "R3");
    end

    // R3: select change outside mgmt reset has no effect
    cfg_sel_i = 4'd15;
    run_op(1'b0, 5'h0A, 5'h15, 16'hC0DE, 8, "R3");
    // R3: largest entry
    mgmt_rst_i = 1'b1; @(negedge clk_i); mgmt_rst_i = 1'b0;
    run_op(1'b1, 5'h15, 5'h0A, 16'h7E81, 64, "R3");
    // R3: back to auto
    cfg_sel_i = 4'd0;
    mgmt_rst_i = 1'b1; @(negedge clk_i); mgmt_rst_i = 1'b0;
    run_op(1'b0, 5'h00, 5'h1F, 16'h0001, 20, "R3");

    // R8 and R2 (alternate ratio 25 -> 28)
    while (a_busy) @(negedge clk_i);
    check(idle_err == 0, "R8", "mdc high while idle", 64'(idle_err), 64'(0));
    check(stab_err == 0, "R8", "mdio moved while mdc high", 64'(stab_err), 64'(0));
    check(a_rises > 0 && a_per_err == 0, "R2", "alt divide 28", 64'(a_per_err), 64'(0));

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule